// File: doc/BRIEF.md
# Byte-Addressed Serial EEPROM Target on a Two-Wire Bus

This block is a two-wire bus target that behaves like an erased serial EEPROM of byte-wide words. It watches SCL and SDA, which arrive already synchronized to `clk`. It pulls SDA low through an output enable, in the open-drain manner, and it recognises START and STOP conditions. It answers only to a slave address that carries a fixed 1010 type code and a three-bit sub-address equal to its strap pins. Up to eight instances can therefore share one bus.

After a write-mode slave address, the master sends two address bytes, high byte first. Any data bytes that follow collect in a page buffer of 32 bytes. The buffer is copied into the array only when a STOP arrives, and only if the last byte before it was acknowledged. A read-mode slave address streams bytes out of the array, starting at the internal address pointer. The pointer is loaded by a write-mode address phase, which is how the master performs a random read. A write-protect input is examined once per data byte. When it is high, the byte is not acknowledged and the whole pending write is dropped.

The array holds `2**MEM_AW` bytes. `MEM_AW = 13` gives the full 8192-byte part. The default of 11 keeps elaboration small, and in that case the address bits above the array width are ignored. Out of reset, every location reads FFh.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe` = 0), and every array location reads back as 8'hFF.
- R2: A slave address byte is acknowledged only when bits 7:4 are 4'b1010 and bits 3:1 equal `strap_i`. Bit 0 = 1 selects read and bit 0 = 0 selects write. On a mismatch, SDA stays released and later bytes are not acknowledged until the next START.
- R3: A write-mode address is followed by two address bytes, high byte first. Address bits at positions MEM_AW and above are ignored. A single data byte followed by STOP stores that byte at the address.
- R4: In a page write, each acknowledged data byte goes to the current address. Only the low 5 address bits then increment, wrapping inside the same 32-byte page, so a later byte overwrites an earlier one in that page. Locations outside the page are unchanged.
- R5: Buffered data reaches the array only on a STOP that follows an acknowledged data byte. A repeated START discards the buffered bytes.
- R6: `wp_i` is sampled at the SCL falling edge that ends bit 0 of each data byte. If it is high, that byte is not acknowledged and the whole pending write is discarded, including bytes already acknowledged.
- R7: In a read, each master ACK (SDA low on the ninth clock) makes the block send the byte at the next address, most significant bit first. The address wraps from 2**MEM_AW-1 to 0. A master NACK ends the transfer and releases SDA.
- R8: A read-mode slave address issued without an address phase starts at the address after the last byte sent.
- R9: `sda_oe` changes only while SCL is low. It is low in the cycle after any START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | When high, SDA is pulled low |
| strap_i | input | 3 | Sub-address strap value |
| wp_i | input | 1 | Write protect, active high |

## Verification
The bound checker watches the line discipline on every cycle. It confirms that SDA drive moves only while SCL is low, that drive is dropped after every START and STOP, and that the block never drives while idle. It also checks that a page write never leaves its 32-byte page and that an array commit happens only directly after an acknowledged data byte. The stored values can only be shown by the bench scenarios, which read the bytes back over the bus. These scenarios cover page rollover overwrites, data dropped by write protect or by a repeated START, address aliasing, the wrap from the top of the array, and the current-address continuation.

// File: rtl/eeprom_target_pkg.sv
package eeprom_target_pkg;

   localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_ACK,
      ST_RDAT,
      ST_MACK
   } link_state_t;

endpackage

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic start_det,
   output logic stop_det,
   output logic scl_rise,
   output logic scl_fall
);

   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   // SDA moving while SCL stays high marks a bus condition
   assign start_det = scl_i &  scl_q &  sda_q & ~sda_i;
   assign stop_det  = scl_i &  scl_q & ~sda_q &  sda_i;
   assign scl_rise  = scl_i & ~scl_q;
   assign scl_fall  = ~scl_i & scl_q;

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
   parameter int PAGE_AW = 5,
   localparam int PAGE_N = 1 << PAGE_AW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  wr_en,
   input  logic [PAGE_AW-1:0]    wr_idx,
   input  logic [7:0]            wr_data,
   output logic [PAGE_N*8-1:0]   slot_data,
   output logic [PAGE_N-1:0]     slot_vld
);

   generate
      for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_vld[g]           <= 1'b0;
               slot_data[g*8 +: 8]   <= 8'hFF;
            end else if (clr) begin
               slot_vld[g]           <= 1'b0;
            end else if (wr_en && wr_idx == PAGE_AW'(g)) begin
               slot_vld[g]           <= 1'b1;
               slot_data[g*8 +: 8]   <= wr_data;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
   parameter int MEM_AW  = 11,
   parameter int PAGE_AW = 5,
   localparam int DEPTH  = 1 << MEM_AW,
   localparam int PAGE_N = 1 << PAGE_AW,
   localparam int PG_W   = MEM_AW - PAGE_AW
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  commit,
   input  logic [PG_W-1:0]       commit_page,
   input  logic [PAGE_N*8-1:0]   slot_data,
   input  logic [PAGE_N-1:0]     slot_vld,
   input  logic [MEM_AW-1:0]     rd_addr,
   output logic [7:0]            rd_data
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (commit) begin
         for (int s = 0; s < PAGE_N; s++) begin
            if (slot_vld[s]) mem[{commit_page, PAGE_AW'(s)}] <= slot_data[s*8 +: 8];
         end
      end
   end

   assign rd_data = mem[rd_addr];

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
   import eeprom_target_pkg::*;
#(
   parameter int MEM_AW  = 11,
   parameter int PAGE_AW = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);

   localparam int PAGE_N = 1 << PAGE_AW;
   localparam int PG_W   = MEM_AW - PAGE_AW;

   generate
      if (PAGE_AW < 1 || PAGE_AW > 7)
         $error("PAGE_AW out of range");
      if (MEM_AW <= PAGE_AW || MEM_AW > 16)
         $error("MEM_AW must exceed PAGE_AW and fit two address bytes");
   endgenerate

   logic start_det, stop_det, scl_rise, scl_fall;

   bus_cond_detect u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .start_det (start_det),
      .stop_det  (stop_det),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall)
   );

   link_state_t        state, after_ack;
   logic [3:0]         bitcnt;
   logic [7:0]         shreg;
   logic [7:0]         txbyte;
   logic [7:0]         addr_hi;
   logic [MEM_AW-1:0]  ptr;
   logic               commit_pend;
   logic [7:0]         rd_data;
   logic [15:0]        full_addr;

   logic               byte_done;
   logic               buf_wr, buf_clr, commit_req;
   logic [PAGE_N*8-1:0] slot_data;
   logic [PAGE_N-1:0]  slot_vld;

   assign byte_done  = scl_fall && (bitcnt == 4'd8);
   assign full_addr  = {addr_hi, shreg};
   assign buf_wr     = (state == ST_WDAT) && byte_done && !wp_i && !start_det && !stop_det;
   assign buf_clr    = start_det || stop_det ||
                       ((state == ST_WDAT) && byte_done && wp_i);
   assign commit_req = stop_det && commit_pend;

   eeprom_page_buf #(.PAGE_AW(PAGE_AW)) u_pbuf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (buf_clr),
      .wr_en     (buf_wr),
      .wr_idx    (ptr[PAGE_AW-1:0]),
      .wr_data   (shreg),
      .slot_data (slot_data),
      .slot_vld  (slot_vld)
   );

   eeprom_array #(.MEM_AW(MEM_AW), .PAGE_AW(PAGE_AW)) u_array (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit_req),
      .commit_page (ptr[MEM_AW-1:PAGE_AW]),
      .slot_data   (slot_data),
      .slot_vld    (slot_vld),
      .rd_addr     (ptr),
      .rd_data     (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         after_ack   <= ST_IDLE;
         bitcnt      <= 4'd0;
         shreg       <= 8'd0;
         txbyte      <= 8'hFF;
         addr_hi     <= 8'd0;
         ptr         <= '0;
         sda_oe      <= 1'b0;
         commit_pend <= 1'b0;
      end else if (start_det) begin
         state       <= ST_DEV;
         bitcnt      <= 4'd0;
         sda_oe      <= 1'b0;
         commit_pend <= 1'b0;
      end else if (stop_det) begin
         state       <= ST_IDLE;
         sda_oe      <= 1'b0;
         commit_pend <= 1'b0;
      end else begin
         case (state)
            ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
               if (scl_rise) begin
                  shreg  <= {shreg[6:0], sda_i};
                  bitcnt <= bitcnt + 4'd1;
               end else if (byte_done) begin
                  bitcnt <= 4'd0;
                  case (state)
                     ST_DEV: begin
                        if (shreg[7:4] == DEV_TYPE_CODE && shreg[3:1] == strap_i) begin
                           sda_oe    <= 1'b1;
                           state     <= ST_ACK;
                           after_ack <= shreg[0] ? ST_RDAT : ST_AHI;
                        end else begin
                           state     <= ST_IDLE;
                        end
                     end
                     ST_AHI: begin
                        addr_hi   <= shreg;
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= ST_ALO;
                     end
                     ST_ALO: begin
                        ptr       <= full_addr[MEM_AW-1:0];
                        sda_oe    <= 1'b1;
                        state     <= ST_ACK;
                        after_ack <= ST_WDAT;
                     end
                     default: begin
                        if (wp_i) begin
                           state       <= ST_IDLE;
                           commit_pend <= 1'b0;
                        end else begin
                           ptr[PAGE_AW-1:0] <= ptr[PAGE_AW-1:0] + 1'b1;
                           commit_pend      <= 1'b1;
                           sda_oe           <= 1'b1;
                           state            <= ST_ACK;
                           after_ack        <= ST_WDAT;
                        end
                     end
                  endcase
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  state  <= after_ack;
                  bitcnt <= 4'd0;
                  if (after_ack == ST_RDAT) begin
                     txbyte <= rd_data;
                     sda_oe <= ~rd_data[7];
                     ptr    <= ptr + 1'b1;
                  end else begin
                     sda_oe <= 1'b0;
                  end
               end
            end
            ST_RDAT: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall) begin
                  if (bitcnt == 4'd8) begin
                     sda_oe <= 1'b0;
                     bitcnt <= 4'd0;
                     state  <= ST_MACK;
                  end else begin
                     txbyte <= {txbyte[6:0], 1'b1};
                     sda_oe <= ~txbyte[6];
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise && sda_i) begin
                  state <= ST_IDLE;
               end else if (scl_fall) begin
                  txbyte <= rd_data;
                  sda_oe <= ~rd_data[7];
                  ptr    <= ptr + 1'b1;
                  bitcnt <= 4'd0;
                  state  <= ST_RDAT;
               end
            end
            default: ;
         endcase
      end
   end

   // observation points for the bound checker
   logic        is_idle;
   logic        in_wr_data;
   logic [15:0] chk_page;
   assign is_idle    = (state == ST_IDLE);
   assign in_wr_data = (state == ST_WDAT) || (state == ST_ACK && after_ack == ST_WDAT);
   assign chk_page   = 16'(ptr[MEM_AW-1:PAGE_AW]);

endmodule

// File: rtl/i2c_eeprom_target_chk.sv
module i2c_eeprom_target_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        scl_i,
   input logic        sda_oe,
   input logic        start_det,
   input logic        stop_det,
   input logic        commit_req,
   input logic        is_idle,
   input logic        in_wr_data,
   input logic [15:0] chk_page
);

   // R9
   sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !$past(scl_i));

   // R9
   cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det || stop_det) |=> !sda_oe);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_idle |-> !sda_oe);

   // R5
   commit_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> $past(in_wr_data));

   // R4
   page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_wr_data && $past(in_wr_data)) |-> (chk_page == $past(chk_page)));

endmodule

bind i2c_eeprom_target i2c_eeprom_target_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_i      (scl_i),
   .sda_oe     (sda_oe),
   .start_det  (start_det),
   .stop_det   (stop_det),
   .commit_req (commit_req),
   .is_idle    (is_idle),
   .in_wr_data (in_wr_data),
   .chk_page   (chk_page)
);

// File: tb/i2c_eeprom_target_bench.sv
module i2c_eeprom_target_bench;

   localparam int CLK_PERIOD = 10;
   localparam int Q          = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [2:0] strap = 3'b101;
   logic       wp = 1'b0;
   logic       sda_oe;
   logic       sda_line;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] rbuf [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   assign sda_line = m_sda & ~sda_oe;

   i2c_eeprom_target u_i2c_eeprom_target (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (m_scl),
      .sda_i   (sda_line),
      .sda_oe  (sda_oe),
      .strap_i (strap),
      .wp_i    (wp)
   );

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic i2c_start();
      m_sda = 1'b1; wait_q();
      m_scl = 1'b1; wait_q();
      m_sda = 1'b0; wait_q();
      m_scl = 1'b0; wait_q();
   endtask

   task automatic i2c_stop();
      m_sda = 1'b0; wait_q();
      m_scl = 1'b1; wait_q();
      m_sda = 1'b1; wait_q();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wait_q();
         m_scl = 1'b1; wait_q();
         m_scl = 1'b0;
      end
      m_sda = 1'b1; wait_q();
      m_scl = 1'b1; wait_q();
      acked = (sda_line == 1'b0);
      m_scl = 1'b0; wait_q();
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      m_sda = 1'b1;
      b = 8'h00;
      for (int i = 0; i < 8; i++) begin
         wait_q();
         m_scl = 1'b1; wait_q();
         b = {b[6:0], sda_line};
         m_scl = 1'b0;
      end
      m_sda = give_ack ? 1'b0 : 1'b1; wait_q();
      m_scl = 1'b1; wait_q();
      m_scl = 1'b0; wait_q();
      m_sda = 1'b1;
   endtask

   function automatic logic [7:0] dev(input logic rd);
      return {4'b1010, 3'b101, rd};
   endfunction

   // write-mode slave address plus two address bytes; the acks are checked
   task automatic addr_phase(input string tag, input logic [15:0] a);
      logic ak;
      i2c_start();
      send_byte(dev(1'b0), ak);   chk8({tag, " dev ack"}, {7'd0, ak}, 8'd1);
      send_byte(a[15:8], ak);     chk8({tag, " ahi ack"}, {7'd0, ak}, 8'd1);
      send_byte(a[7:0], ak);      chk8({tag, " alo ack"}, {7'd0, ak}, 8'd1);
   endtask

   task automatic write_bytes(input string tag, input logic [15:0] a, input int n, input logic [7:0] base, input logic [7:0] step);
      logic ak;
      addr_phase(tag, a);
      for (int i = 0; i < n; i++) begin
         send_byte(8'(base + step * 8'(i)), ak);
         chk8({tag, " data ack"}, {7'd0, ak}, 8'd1);
      end
      i2c_stop();
   endtask

   task automatic read_cont(input string tag, input int n);
      logic ak;
      i2c_start();
      send_byte(dev(1'b1), ak); chk8({tag, " rd dev ack"}, {7'd0, ak}, 8'd1);
      for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
      i2c_stop();
   endtask

   task automatic read_at(input string tag, input logic [15:0] a, input int n);
      addr_phase(tag, a);
      read_cont(tag, n);
   endtask

   task automatic t_reset();
      chk8("R1 reset sda_oe", {7'd0, sda_oe}, 8'd0);
      chk8("R9 reset sda_oe", {7'd0, sda_oe}, 8'd0);
      read_at("R1", 16'h0005, 2);
      chk8("R1 erased 0x005", rbuf[0], 8'hFF);
      chk8("R1 erased 0x006", rbuf[1], 8'hFF);
   endtask

   task automatic t_addressing();
      logic ak;
      // R2: wrong strap value
      i2c_start();
      send_byte({4'b1010, 3'b100, 1'b0}, ak); chk8("R2 strap mismatch nack", {7'd0, ak}, 8'd0);
      send_byte(8'h00, ak);                   chk8("R2 ignored after mismatch", {7'd0, ak}, 8'd0);
      send_byte({4'b1010, 3'b101, 1'b0}, ak); chk8("R2 ignored until START", {7'd0, ak}, 8'd0);
      i2c_stop();
      // R2: wrong type code
      i2c_start();
      send_byte({4'b1011, 3'b101, 1'b0}, ak); chk8("R2 type mismatch nack", {7'd0, ak}, 8'd0);
      i2c_stop();
      // R2: another strap value selects the same block
      strap = 3'b010;
      i2c_start();
      send_byte({4'b1010, 3'b010, 1'b1}, ak); chk8("R2 new strap ack", {7'd0, ak}, 8'd1);
      i2c_stop();
      strap = 3'b101;
   endtask

   task automatic t_byte_write();
      write_bytes("R3", 16'h0123, 1, 8'h5A, 8'h00);
      read_at("R3", 16'h0123, 1);
      chk8("R3 byte write readback", rbuf[0], 8'h5A);
      read_at("R3", 16'hF923, 1);
      chk8("R3 upper address bits ignored", rbuf[0], 8'h5A);
   endtask

   task automatic t_page();
      write_bytes("R4", 16'h0240, 32, 8'h10, 8'h01);
      read_at("R4", 16'h0240, 32);
      for (int i = 0; i < 32; i++) chk8("R4 full page", rbuf[i], 8'(8'h10 + i));
      // rollover: 0x29E,0x29F then wrap to 0x280,0x281
      write_bytes("R4", 16'h029E, 4, 8'hA0, 8'h01);
      read_at("R4", 16'h0280, 2);
      chk8("R4 rollover 0x280", rbuf[0], 8'hA2);
      chk8("R4 rollover 0x281", rbuf[1], 8'hA3);
      read_at("R4", 16'h029E, 3);
      chk8("R4 page end 0x29E", rbuf[0], 8'hA0);
      chk8("R4 page end 0x29F", rbuf[1], 8'hA1);
      chk8("R4 next page untouched", rbuf[2], 8'hFF);
   endtask

   task automatic t_commit();
      logic ak;
      addr_phase("R5", 16'h0300);
      send_byte(8'h77, ak); chk8("R5 data ack", {7'd0, ak}, 8'd1);
      // repeated START straight into a random read of the same address
      addr_phase("R5", 16'h0300);
      read_cont("R5", 1);
      chk8("R5 repeated START discards", rbuf[0], 8'hFF);
      read_at("R5", 16'h0300, 1);
      chk8("R5 still erased", rbuf[0], 8'hFF);
   endtask

   task automatic t_wp();
      logic ak;
      addr_phase("R6", 16'h0400);
      send_byte(8'h11, ak); chk8("R6 unprotected ack", {7'd0, ak}, 8'd1);
      wp = 1'b1;
      send_byte(8'h22, ak); chk8("R6 protected nack", {7'd0, ak}, 8'd0);
      wp = 1'b0;
      i2c_stop();
      read_at("R6", 16'h0400, 2);
      chk8("R6 first byte dropped", rbuf[0], 8'hFF);
      chk8("R6 second byte dropped", rbuf[1], 8'hFF);
   endtask

   task automatic t_seq_wrap();
      write_bytes("R7", 16'h07FE, 2, 8'hA1, 8'h01);
      write_bytes("R7", 16'h0000, 2, 8'hB0, 8'h13);
      read_at("R7", 16'h07FE, 3);
      chk8("R7 seq 0x7FE", rbuf[0], 8'hA1);
      chk8("R7 seq 0x7FF", rbuf[1], 8'hA2);
      chk8("R7 wrap to 0x000", rbuf[2], 8'hB0);
      chk8("R7 released after NACK", {7'd0, sda_oe}, 8'd0);
      read_cont("R8", 1);
      chk8("R8 current address", rbuf[0], 8'hC3);
   endtask

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_addressing();
      t_byte_write();
      t_page();
      t_commit();
      t_wp();
      t_seq_wrap();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule